// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of an event timer. It watches the value of a free-running main counter that lives elsewhere and emits a single-cycle fire pulse when the counter reaches the channel's comparator. The channel runs in one-shot or periodic mode. It compares either the full counter width or only the low half of the counter; the low-half setting is called narrow mode below. Generating the counter and turning the fire pulse into an interrupt are handled by neighbouring logic.

Software programs the channel through three word-wide write strobes: one for the configuration word, one for the comparator low word and one for the comparator high word. The configuration and the comparator are always visible on the readback ports. The channel also holds a period register and a wrap flag that cannot be read. In periodic mode a comparator write normally reloads only the period. A set-value bit lets that write place the comparator as well. In narrow one-shot mode the channel fires an extra event when the low half of the counter wraps, if the wrap comes before the match. All pins are plain control and status signals with no valid/ready handshake, so no back-pressure applies. A write strobe is taken in the cycle it is high. If several strobes are high in the same cycle, the configuration strobe wins, then the low word, then the high word.

Top module: `ctc_channel`

## Requirements
- R1: After reset, `cfg_o` reads 64'h0000_0004_0000_0030, `cmp_o` reads all ones and `fire_o` is 0. The period register and the wrap flag are zero.
- R2: The configuration word has four writable bits: bit 0 enables the channel, bit 1 selects periodic mode, bit 2 selects narrow mode and bit 3 is the set-value bit. Bits 4 and 5 always read 1. The upper word reads the route-availability value 4. Writes to every other bit are ignored.
- R3: In one-shot mode a write to either comparator word replaces that half of the comparator. The enabled channel gives one single-cycle `fire_o` pulse when the counter equals the comparator, then stays quiet until it is re-armed. It is re-armed by a rising channel enable or by a comparator write while enabled.
- R4: `fire_o` stays low whenever `glb_en_i` or the channel enable bit is 0. An armed channel that was held off by `glb_en_i` still fires when the counter reaches its comparator after `glb_en_i` returns to 1.
- R5: In periodic mode with the set-value bit clear, a comparator write loads only the period and leaves `cmp_o` unchanged. With the set-value bit set, the same write loads both the comparator and the period.
- R6: The set-value bit reads 0 after any write to either comparator word.
- R7: In periodic mode with a non-zero period, each match fires and advances the comparator by the period.
- R8: A value loaded into the period has its top bit cleared. In narrow mode that is bit 31 of the low word; in full-width mode it is bit 63.
- R9: In narrow mode only the low 32 bits of the counter and the comparator are compared. Comparator sums wrap at 32 bits. Writes to the high comparator word leave the comparator and the period unchanged.
- R10: Writing the configuration with the narrow bit set clears the upper halves of the comparator and the period. While narrow mode is on, `cmp_o[63:32]` stays 0.
- R11: In narrow one-shot mode the wrap flag is set at arming when the counter's low word is above the comparator's low word. The channel then fires when the low word reaches 32'hFFFF_FFFF, clears the flag, and fires again at the real match.
- R12: If a periodic channel finds the counter at or past its comparator, compared by the sign of their difference, it adds the period once per cycle without firing until the comparator is ahead again.
- R13: In periodic mode with a zero period, a match still fires but the comparator is not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Current main counter value |
| glb_en_i | input | 1 | Global enable for all fire events |
| wr_cfg_i | input | 1 | Write strobe for the configuration word |
| wr_cmp_lo_i | input | 1 | Write strobe for the comparator low word |
| wr_cmp_hi_i | input | 1 | Write strobe for the comparator high word |
| wdata_i | input | CNT_W/2 | Write data word |
| cfg_o | output | CNT_W | Configuration readback |
| cmp_o | output | CNT_W | Comparator readback |
| fire_o | output | 1 | Single-cycle match event |

## Verification
The bench builds the channel with its default parameters: a 64-bit counter, 32-bit register words and a route-availability value of 4. The bench drives the counter itself rather than counting up from zero. It can therefore place the counter just below any target, such as a low word near 32'hFFFF_FFFF or a value with bit 31 set. This makes narrow-mode wrap events, masked periods and signed catch-up ordering reachable within a few dozen cycles each.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int CFG_EN      = 0;
  localparam int CFG_PER     = 1;
  localparam int CFG_NARROW  = 2;
  localparam int CFG_SETVAL  = 3;
  localparam int CFG_PCAP    = 4;
  localparam int CFG_WCAP    = 5;
  localparam int CFG_RW_BITS = 4;

  // bit order matches CFG_* positions (first member is the MSB)
  typedef struct packed {
    logic setval;
    logic narrow;
    logic periodic;
    logic enable;
  } ctc_mode_t;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_CFG  = 2'd1,
    WR_LO   = 2'd2,
    WR_HI   = 2'd3
  } ctc_wr_e;
endpackage

// File: rtl/ctc_cfg_reg.sv
module ctc_cfg_reg
  import ctc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int unsigned ROUTE_CAPS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctc_wr_e                wr_kind,
  input  logic [CFG_RW_BITS-1:0] wdata_rw,
  output ctc_mode_t              mode_q,
  output ctc_mode_t              mode_nxt,
  output logic                   en_rise,
  output logic                   en_fall,
  output logic [CNT_W-1:0]       cfg_rd
);
  localparam int W = CNT_W / 2;

  ctc_mode_t mode_r;

  always_comb begin
    mode_nxt = mode_r;
    if (wr_kind == WR_CFG) begin
      mode_nxt = ctc_mode_t'(wdata_rw);
    end else if (wr_kind == WR_LO || wr_kind == WR_HI) begin
      mode_nxt.setval = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_r <= '0;
    else        mode_r <= mode_nxt;
  end

  assign en_rise = (wr_kind == WR_CFG) &&  wdata_rw[CFG_EN] && !mode_r.enable;
  assign en_fall = (wr_kind == WR_CFG) && !wdata_rw[CFG_EN] &&  mode_r.enable;
  assign mode_q  = mode_r;

  always_comb begin
    cfg_rd                  = '0;
    cfg_rd[CFG_RW_BITS-1:0] = mode_r;
    cfg_rd[CFG_PCAP]        = 1'b1;
    cfg_rd[CFG_WCAP]        = 1'b1;
    cfg_rd[CNT_W-1:W]       = W'(ROUTE_CAPS);
  end
endmodule

// File: rtl/ctc_cmp_store.sv
module ctc_cmp_store
  import ctc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctc_wr_e          wr_kind,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic             narrow,
  input  logic             periodic,
  input  logic             setval,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W/2-1:0] cmp_nxt_lo
);
  localparam int W = CNT_W / 2;
  localparam logic [W-1:0] TOP_OFF = {1'b0, {(W-1){1'b1}}};

  logic [CNT_W-1:0] cmp_r, per_r, cmp_d, per_d, sum;
  logic [W-1:0]     lo_mask;
  logic             take_cmp;

  assign lo_mask  = narrow ? TOP_OFF : '1;
  assign take_cmp = !periodic || setval;
  assign sum      = cmp_r + per_r;

  always_comb begin
    cmp_d = cmp_r;
    per_d = per_r;
    unique case (wr_kind)
      WR_CFG: begin
        if (wdata[CFG_NARROW]) begin
          cmp_d[CNT_W-1:W] = '0;
          per_d[CNT_W-1:W] = '0;
        end
      end
      WR_LO: begin
        if (take_cmp) cmp_d[W-1:0] = wdata;
        if (periodic) per_d[W-1:0] = wdata & lo_mask;
      end
      WR_HI: begin
        if (!narrow) begin
          if (take_cmp) cmp_d[CNT_W-1:W] = wdata;
          if (periodic) per_d[CNT_W-1:W] = wdata & TOP_OFF;
        end
      end
      default: begin
        if (adv_i) begin
          if (narrow) cmp_d = {{W{1'b0}}, sum[W-1:0]};
          else        cmp_d = sum;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_r <= '1;
      per_r <= '0;
    end else begin
      cmp_r <= cmp_d;
      per_r <= per_d;
    end
  end

  assign cmp_q      = cmp_r;
  assign per_q      = per_r;
  assign cmp_nxt_lo = cmp_d[W-1:0];
endmodule

// File: rtl/ctc_match.sv
module ctc_match #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             glb_en_i,
  input  logic             enable,
  input  logic             periodic,
  input  logic             narrow,
  input  logic             narrow_nxt,
  input  logic             periodic_nxt,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic [CNT_W-1:0] per_q,
  input  logic [CNT_W/2-1:0] cmp_nxt_lo,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic             cmp_wr,
  output logic             adv_o,
  output logic             fire_o
);
  localparam int W = CNT_W / 2;

  logic             armed_q, wrap_q, fire_q;
  logic [CNT_W-1:0] diff_full;
  logic [W-1:0]     diff_half;
  logic             eq, reached, live, wrap_mode, wrap_hit, real_hit, hit, rearm;

  assign diff_full = count_i - cmp_q;
  assign diff_half = count_i[W-1:0] - cmp_q[W-1:0];

  always_comb begin
    if (narrow) begin
      eq      = (count_i[W-1:0] == cmp_q[W-1:0]);
      reached = !diff_half[W-1];
    end else begin
      eq      = (count_i == cmp_q);
      reached = !diff_full[CNT_W-1];
    end
  end

  assign live      = armed_q && enable && glb_en_i;
  assign wrap_mode = narrow && !periodic && wrap_q;
  assign wrap_hit  = wrap_mode && (count_i[W-1:0] == '1);
  assign real_hit  = !wrap_mode && eq;
  assign hit       = live && (wrap_hit || real_hit);
  assign adv_o     = live && periodic && (per_q != '0) && reached;
  assign rearm     = en_rise || (cmp_wr && enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= hit;
      if (en_fall) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (rearm) begin
        armed_q <= 1'b1;
        wrap_q  <= narrow_nxt && !periodic_nxt && (count_i[W-1:0] > cmp_nxt_lo);
      end else if (hit) begin
        if (wrap_hit)       wrap_q  <= 1'b0;
        else if (!periodic) armed_q <= 1'b0;
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int unsigned ROUTE_CAPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             glb_en_i,
  input  logic             wr_cfg_i,
  input  logic             wr_cmp_lo_i,
  input  logic             wr_cmp_hi_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  output logic [CNT_W-1:0] cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             fire_o
);
  localparam int W = CNT_W / 2;

  ctc_wr_e          wr_kind;
  ctc_mode_t        mode_q, mode_nxt;
  logic             en_rise, en_fall, adv;
  logic [CNT_W-1:0] cmp_q, per_q;
  logic [W-1:0]     cmp_nxt_lo;

  always_comb begin
    if (wr_cfg_i)         wr_kind = WR_CFG;
    else if (wr_cmp_lo_i) wr_kind = WR_LO;
    else if (wr_cmp_hi_i) wr_kind = WR_HI;
    else                  wr_kind = WR_NONE;
  end

  ctc_cfg_reg #(.CNT_W(CNT_W), .ROUTE_CAPS(ROUTE_CAPS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_kind  (wr_kind),
    .wdata_rw (wdata_i[CFG_RW_BITS-1:0]),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .cfg_rd   (cfg_o)
  );

  ctc_cmp_store #(.CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_kind    (wr_kind),
    .wdata      (wdata_i),
    .narrow     (mode_q.narrow),
    .periodic   (mode_q.periodic),
    .setval     (mode_q.setval),
    .adv_i      (adv),
    .cmp_q      (cmp_q),
    .per_q      (per_q),
    .cmp_nxt_lo (cmp_nxt_lo)
  );

  ctc_match #(.CNT_W(CNT_W)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_i      (count_i),
    .glb_en_i     (glb_en_i),
    .enable       (mode_q.enable),
    .periodic     (mode_q.periodic),
    .narrow       (mode_q.narrow),
    .narrow_nxt   (mode_nxt.narrow),
    .periodic_nxt (mode_nxt.periodic),
    .cmp_q        (cmp_q),
    .per_q        (per_q),
    .cmp_nxt_lo   (cmp_nxt_lo),
    .en_rise      (en_rise),
    .en_fall      (en_fall),
    .cmp_wr       ((wr_kind == WR_LO) || (wr_kind == WR_HI)),
    .adv_o        (adv),
    .fire_o       (fire_o)
  );

  assign cmp_o = cmp_q;
endmodule

// File: rtl/ctc_channel_chk.sv
module ctc_channel_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en_i,
  input logic             wr_cfg_i,
  input logic             wr_cmp_lo_i,
  input logic             wr_cmp_hi_i,
  input logic [CNT_W-1:0] cfg_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic             fire_o
);
  localparam int W = CNT_W / 2;

  logic wr_any;
  assign wr_any = wr_cfg_i || wr_cmp_lo_i || wr_cmp_hi_i;

  assert_oneshot_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !$past(wr_any) && !cfg_o[1] && !cfg_o[2]) |=> !fire_o);

  assert_oneshot_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_o[1] && !wr_any) |=> $stable(cmp_o));

  assert_gated_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_i || !cfg_o[0]) |=> !fire_o);

  assert_setval_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_cmp_lo_i || wr_cmp_hi_i) && !wr_cfg_i) |=> !cfg_o[3]);

  assert_narrow_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[2] |-> (cmp_o[CNT_W-1:W] == '0));
endmodule

bind ctc_channel ctc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en_i    (glb_en_i),
  .wr_cfg_i    (wr_cfg_i),
  .wr_cmp_lo_i (wr_cmp_lo_i),
  .wr_cmp_hi_i (wr_cmp_hi_i),
  .cfg_o       (cfg_o),
  .cmp_o       (cmp_o),
  .fire_o      (fire_o)
);

// File: tb/ctc_channel_tb_top.sv
module ctc_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic             glb_en = 1'b0;
  logic             wr_cfg = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [31:0]      wdata = '0;
  logic [CNT_W-1:0] cfg_o, cmp_o;
  logic             fire_o;

  int n_cmp = 0, n_bad = 0, nfire = 0;
  logic [63:0] fire_at [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .count_i(count), .glb_en_i(glb_en),
    .wr_cfg_i(wr_cfg), .wr_cmp_lo_i(wr_lo), .wr_cmp_hi_i(wr_hi),
    .wdata_i(wdata), .cfg_o(cfg_o), .cmp_o(cmp_o), .fire_o(fire_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sel: 1 config, 2 comparator low, 3 comparator high
  task automatic wr(input int sel, input logic [31:0] d);
    wdata  = d;
    wr_cfg = (sel == 1);
    wr_lo  = (sel == 2);
    wr_hi  = (sel == 3);
    @(posedge clk); #1;
    wr_cfg = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic step(input int n, input bit move);
    nfire = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (fire_o) begin
        if (nfire < 8) fire_at[nfire] = count;
        nfire++;
      end
      if (move) count = count + 1;
    end
  endtask

  task automatic t_reset_layout;
    chk("R1 cfg", cfg_o, 64'h0000_0004_0000_0030);
    chk("R1 cmp", cmp_o, '1);
    chk("R1 fire", {63'd0, fire_o}, 64'd0);
    wr(1, 32'hFFFF_FFC0);
    chk("R2 cfg ignores other bits", cfg_o, 64'h0000_0004_0000_0030);
  endtask

  task automatic t_oneshot;
    glb_en = 1'b1; count = 64'd100;
    wr(2, 32'd110); wr(3, 32'd0);
    chk("R3 cmp write", cmp_o, 64'd110);
    wr(1, 32'h1);
    step(30, 1);
    chk("R3 fire count", nfire, 1);
    chk("R3 fire point", fire_at[0], 64'd110);
  endtask

  task automatic t_gating;
    glb_en = 1'b0;
    wr(1, 32'h0); wr(2, 32'd130); wr(1, 32'h1);
    count = 64'd125; step(10, 1);
    chk("R4 global off", nfire, 0);
    glb_en = 1'b1; count = 64'd128; step(5, 1);
    chk("R4 resume fires", nfire, 1);
    chk("R4 resume point", fire_at[0], 64'd130);
    wr(1, 32'h0); wr(2, 32'd140);
    count = 64'd138; step(5, 1);
    chk("R4 channel off", nfire, 0);
  endtask

  task automatic t_periodic;
    wr(1, 32'hA);
    wr(2, 32'd300);
    chk("R6 setval cleared", {63'd0, cfg_o[3]}, 64'd0);
    chk("R5 setval loads cmp", cmp_o, 64'd300);
    wr(3, 32'd0); wr(2, 32'd7);
    chk("R5 period-only write", cmp_o, 64'd300);
    wr(1, 32'h3);
    count = 64'd290; step(30, 1);
    chk("R7 fire count", nfire, 3);
    chk("R7 fire 0", fire_at[0], 64'd300);
    chk("R7 fire 1", fire_at[1], 64'd307);
    chk("R7 fire 2", fire_at[2], 64'd314);
    chk("R7 cmp advanced", cmp_o, 64'd321);
  endtask

  task automatic t_narrow_periodic;
    wr(1, 32'h0); wr(1, 32'hE);
    wr(2, 32'h8000_0010);
    wr(3, 32'h77);
    chk("R9 high write ignored", cmp_o, 64'h8000_0010);
    wr(1, 32'h7);
    count = 64'h5_8000_0008; step(41, 1);
    chk("R8 fire count", nfire, 3);
    chk("R8 fire 0", fire_at[0], 64'h5_8000_0010);
    chk("R8 fire 1", fire_at[1], 64'h5_8000_0020);
    chk("R9 fire 2", fire_at[2], 64'h5_8000_0030);
    chk("R9 cmp 32-bit", cmp_o, 64'h8000_0040);
  endtask

  task automatic t_truncate;
    wr(1, 32'h0);
    wr(3, 32'hABCD);
    chk("R10 upper loaded", cmp_o, 64'h0000_ABCD_8000_0040);
    wr(1, 32'h4);
    chk("R10 upper cleared", cmp_o, 64'h8000_0040);
  endtask

  task automatic t_wrap;
    wr(2, 32'h10);
    count = 64'h1_FFFF_FFF0;
    wr(1, 32'h5);
    step(40, 1);
    chk("R11 fire count", nfire, 2);
    chk("R11 wrap fire", fire_at[0], 64'h1_FFFF_FFFF);
    chk("R11 real fire", fire_at[1], 64'h2_0000_0010);
  endtask

  task automatic t_catchup;
    wr(1, 32'h0); wr(1, 32'hA);
    wr(2, 32'd400); wr(3, 32'd0); wr(2, 32'd10);
    count = 64'd435;
    wr(1, 32'h3);
    step(6, 0);
    chk("R12 silent catch-up", nfire, 0);
    chk("R12 cmp ahead", cmp_o, 64'd440);
    step(20, 1);
    chk("R12 fire count", nfire, 2);
    chk("R12 fire 0", fire_at[0], 64'd440);
    chk("R12 fire 1", fire_at[1], 64'd450);
  endtask

  task automatic t_zero_period;
    wr(1, 32'h0); wr(1, 32'hA);
    wr(2, 32'd600); wr(2, 32'd0);
    wr(1, 32'h3);
    count = 64'd590; step(30, 1);
    chk("R13 fire count", nfire, 1);
    chk("R13 fire point", fire_at[0], 64'd600);
    chk("R13 cmp unchanged", cmp_o, 64'd600);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_layout();
    t_oneshot();
    t_gating();
    t_periodic();
    t_narrow_periodic();
    t_truncate();
    t_wrap();
    t_catchup();
    t_zero_period();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule